// File: doc/BRIEF.md
# SPI EEPROM Page-Write Front End

This block is the write side of a small serial EEPROM. It works as an SPI slave: a command byte is shifted in on the data input, most significant bit first, while chip select is held low. A write command carries a 16-bit address and from one to a page's worth of data bytes. Those bytes are collected in a page buffer and are only committed to the on-chip byte array after chip select goes high. A status-read command returns a byte holding a busy flag and the write-enable flag.

All SPI pins are brought into the system clock domain by synchronizers and sampled by edge detection. As a result, SPI mode 0 (clock idles low) and mode 3 (clock idles high) behave the same way. Programming time is modelled by a counter in the system clock domain. While the counter runs, only status reads are answered. The byte array has a combinational read port so the surrounding chip can see committed data.

Only the low `ADDR_BITS` address bits select a byte. The low log2(`PAGE_BYTES`) of those bits are the offset within a page and the rest are the page number. `ADDR_BITS` must lie between 9 and 16.

Top module: `spi_eeprom_page_wr`

## Requirements
- R1: After reset, `spi_miso_oe` is 0, a status read returns 8'h00, and every byte of the array reads 8'h00.
- R2: Command byte 8'h06 sets the write-enable flag when the block is not busy; the flag is status bit 1.
- R3: Command byte 8'h02 is accepted only while the write-enable flag is set; without it the frame writes nothing and no programming cycle starts.
- R4: The 16-bit address follows the write command MSB first; only its low ADDR_BITS bits are used and the upper bits have no effect.
- R5: Data bytes after the address go to consecutive offsets in the page, starting at the address offset, with the page number held fixed.
- R6: When loading passes the last offset of a page, it continues at offset 0 of the same page, and a later byte for an offset replaces an earlier one.
- R7: The array is not changed and no programming starts while chip select stays low, however long that lasts; programming begins only when chip select rises.
- R8: During programming, status bit 0 reads 1 for PROG_CYCLES system clocks, then 0.
- R9: While busy, every command other than status read (8'h05) is ignored, and status reads still work.
- R10: When programming ends, the write-enable flag clears, so status reads 8'h00.
- R11: If chip select rises with a partial data byte pending, or with no complete data byte at all, no programming starts, the loaded bytes are discarded, and the write-enable flag is kept.
- R12: `spi_miso_oe` is 1 only during the data phase of a status read. Status bits are shifted out MSB first, changing after falling clock edges. The status byte repeats for as long as the clock runs.
- R13: Frames give identical results in SPI mode 0 and mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial status data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 means high impedance |
| rd_addr | input | ADDR_BITS | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |

## Verification
SPI pins pass through two synchronizer stages and one edge-detect register. A status bit therefore reaches `spi_miso` three system clocks after the falling SCK edge that requests it. The bench keeps each SCK half period at six clocks and reads `spi_miso` just before the next rising edge. A committed page appears on `rd_data` PROG_CYCLES clocks after the synchronized chip-select rise. The bench therefore checks the array only after waiting PROG_CYCLES plus a margin, and checks busy with a status frame that completes well inside the programming window.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam logic [7:0] OP_PROGRAM = 8'h02;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_ARM     = 8'h06;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DATA,
        PH_STATUS,
        PH_DISCARD
    } phase_e;

    typedef struct packed {
        logic [5:0] spare;
        logic       armed;
        logic       busy;
    } stat_t;

    typedef struct packed {
        logic active;
        logic sck_up;
        logic sck_dn;
        logic sel_fall;
        logic sel_rise;
        logic mosi;
    } pin_evt_t;

    function automatic logic [7:0] stat_byte(input logic armed, input logic busy);
        stat_t s;
        s.spare = '0;
        s.armed = armed;
        s.busy  = busy;
        return s;
    endfunction

endpackage

// File: rtl/eepw_pin_sync.sv
module eepw_pin_sync
    import eepw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     mosi,
    output pin_evt_t ev
);
    // bit 2 = sck, bit 1 = cs_n, bit 0 = mosi
    logic [2:0] stg [SYNC_STAGES];
    logic [2:1] prev_q;
    logic [2:0] now_s;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= 3'b010;
        else     stg[0] <= {sck, cs_n, mosi};
    end

    for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= 3'b010;
            else     stg[k] <= stg[k-1];
        end
    end

    assign now_s = stg[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 2'b01;
        else     prev_q <= now_s[2:1];
    end

    always_comb begin
        ev.active   = ~now_s[1];
        ev.sck_up   =  now_s[2] & ~prev_q[2];
        ev.sck_dn   = ~now_s[2] &  prev_q[2];
        ev.sel_fall = ~now_s[1] &  prev_q[1];
        ev.sel_rise =  now_s[1] & ~prev_q[1];
        ev.mosi     =  now_s[0];
    end

endmodule

// File: rtl/eepw_frame_ctl.sv
module eepw_frame_ctl
    import eepw_pkg::*;
#(
    parameter int ADDR_BITS  = 10,
    parameter int PAGE_BYTES = 32,
    localparam int OFF_BITS  = $clog2(PAGE_BYTES),
    localparam int PG_BITS   = ADDR_BITS - OFF_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  pin_evt_t            ev,
    input  logic                busy,
    input  logic                armed,
    input  logic [7:0]          stat,
    output logic                arm_set,
    output logic                buf_we,
    output logic [OFF_BITS-1:0] buf_idx,
    output logic [7:0]          buf_byte,
    output logic                prog_go,
    output logic [PG_BITS-1:0]  page_q,
    output logic                so,
    output logic                so_oe
);
    phase_e                ph_q, next_ph;
    logic [2:0]            bit_q;
    logic [6:0]            sh_q;
    logic [ADDR_BITS-9:0]  hi_q;
    logic                  hi_done_q;
    logic [OFF_BITS-1:0]   off_q;
    logic                  got_q;
    logic [6:0]            osh_q;
    logic [2:0]            oidx_q;
    logic                  so_q;

    logic [7:0]            byte_in;
    logic [ADDR_BITS-1:0]  full_a;
    logic                  byte_done;

    assign byte_in   = {sh_q, ev.mosi};
    assign full_a    = {hi_q, byte_in};
    assign byte_done = !ev.sel_fall && ev.active && ev.sck_up && (bit_q == 3'd7);

    // Decision taken when the command byte completes
    always_comb begin
        if (busy) begin
            next_ph = (byte_in == OP_STATUS) ? PH_STATUS : PH_DISCARD;
        end else begin
            case (byte_in)
                OP_PROGRAM: next_ph = armed ? PH_ADDR : PH_DISCARD;
                OP_STATUS:  next_ph = PH_STATUS;
                default:    next_ph = PH_DISCARD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_OPCODE;
            bit_q     <= '0;
            sh_q      <= '0;
            hi_q      <= '0;
            hi_done_q <= 1'b0;
            off_q     <= '0;
            page_q    <= '0;
            got_q     <= 1'b0;
            osh_q     <= '0;
            oidx_q    <= '0;
            so_q      <= 1'b0;
        end else if (ev.sel_fall) begin
            ph_q      <= PH_OPCODE;
            bit_q     <= '0;
            hi_done_q <= 1'b0;
            got_q     <= 1'b0;
            oidx_q    <= '0;
        end else if (ev.active && ev.sck_up) begin
            sh_q  <= byte_in[6:0];
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
                case (ph_q)
                    PH_OPCODE: ph_q <= next_ph;
                    PH_ADDR: begin
                        if (!hi_done_q) begin
                            hi_q      <= byte_in[ADDR_BITS-9:0];
                            hi_done_q <= 1'b1;
                        end else begin
                            ph_q   <= PH_DATA;
                            off_q  <= full_a[OFF_BITS-1:0];
                            page_q <= full_a[ADDR_BITS-1:OFF_BITS];
                        end
                    end
                    PH_DATA: begin
                        off_q <= off_q + 1'b1;   // wraps inside the page
                        got_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (ev.active && ev.sck_dn && ph_q == PH_STATUS) begin
            if (oidx_q == 3'd0) begin
                so_q  <= stat[7];
                osh_q <= stat[6:0];
            end else begin
                so_q  <= osh_q[6];
                osh_q <= {osh_q[5:0], 1'b0};
            end
            oidx_q <= oidx_q + 3'd1;
        end
    end

    assign arm_set  = byte_done && ph_q == PH_OPCODE && !busy && byte_in == OP_ARM;
    assign buf_we   = byte_done && ph_q == PH_DATA;
    assign buf_idx  = off_q;
    assign buf_byte = byte_in;
    assign prog_go  = ev.sel_rise && ph_q == PH_DATA && bit_q == 3'd0 && got_q && !busy;
    assign so       = so_q;
    assign so_oe    = ev.active && ph_q == PH_STATUS;

endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_BITS  = $clog2(PAGE_BYTES)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [OFF_BITS-1:0]            idx,
    input  logic [7:0]                     wdata,
    input  logic                           clr,
    output logic [PAGE_BYTES-1:0][7:0]     data_q,
    output logic [PAGE_BYTES-1:0]          mask_q
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g] <= 1'b0;
                data_q[g] <= '0;
            end else if (clr) begin
                mask_q[g] <= 1'b0;
            end else if (we && idx == OFF_BITS'(g)) begin
                data_q[g] <= wdata;
                mask_q[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/eepw_prog_timer.sv
module eepw_prog_timer #(
    parameter int PROG_CYCLES = 5000,
    localparam int CW = $clog2(PROG_CYCLES)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt_q;

    assign done = busy && (cnt_q == CW'(PROG_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (!busy && start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_eeprom_page_wr.sv
module spi_eeprom_page_wr
    import eepw_pkg::*;
#(
    parameter int ADDR_BITS   = 10,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 5000,
    parameter int SYNC_STAGES = 2,
    localparam int OFF_BITS   = $clog2(PAGE_BYTES),
    localparam int PG_BITS    = ADDR_BITS - OFF_BITS,
    localparam int DEPTH      = 1 << ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    output logic                 spi_miso_oe,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [7:0]           rd_data
);
    pin_evt_t                       ev;
    logic                           armed_q, arm_set;
    logic                           busy, done;
    logic                           buf_we, buf_clr, prog_go;
    logic [OFF_BITS-1:0]            buf_idx;
    logic [7:0]                     buf_byte;
    logic [PG_BITS-1:0]             page_q;
    logic [PAGE_BYTES-1:0][7:0]     pg_data;
    logic [PAGE_BYTES-1:0]          pg_mask;
    logic [7:0]                     stat;
    logic                           cs_up, cs_act;
    logic [7:0]                     cells [DEPTH];

    assign cs_up  = ev.sel_rise;
    assign cs_act = ev.active;
    assign stat   = stat_byte(armed_q, busy);

    eepw_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .ev(ev)
    );

    eepw_frame_ctl #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES)) u_ctl (
        .clk(clk), .rst(rst), .ev(ev), .busy(busy), .armed(armed_q), .stat(stat),
        .arm_set(arm_set), .buf_we(buf_we), .buf_idx(buf_idx), .buf_byte(buf_byte),
        .prog_go(prog_go), .page_q(page_q), .so(spi_miso), .so_oe(spi_miso_oe)
    );

    // Discard on an aborted frame; keep contents while a cycle is pending
    assign buf_clr = (cs_up && !prog_go && !busy) || done;

    eepw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst(rst), .we(buf_we), .idx(buf_idx), .wdata(buf_byte),
        .clr(buf_clr), .data_q(pg_data), .mask_q(pg_mask)
    );

    eepw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(prog_go), .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst)          armed_q <= 1'b0;
        else if (done)    armed_q <= 1'b0;
        else if (arm_set) armed_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (done) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (pg_mask[j]) cells[{page_q, OFF_BITS'(j)}] <= pg_data[j];
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

module eepw_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic armed,
    input logic cs_up,
    input logic cs_active,
    input logic so_oe
);
    // R2
    arm_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(!busy));
    // R3
    start_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> armed);
    // R7
    start_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_up));
    // R9
    arm_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(armed));
    // R10
    arm_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !armed);
    // R12
    miso_selected_chk: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> cs_active);
endmodule

bind spi_eeprom_page_wr eepw_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .armed(armed_q),
    .cs_up(cs_up), .cs_active(cs_act), .so_oe(spi_miso_oe)
);

// File: tb/spi_eeprom_page_wr_test.sv
`timescale 1ns/1ps
module spi_eeprom_page_wr_test;
    localparam int AB    = 10;
    localparam int PROG  = 1500;
    localparam int H     = 6;
    localparam int DEPTH = 1 << AB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [AB-1:0] rd_addr = '0;
    wire  miso, miso_oe;
    wire  [7:0] rd_data;

    int checks = 0, fails = 0;
    bit finished = 0;
    bit mode3 = 0;
    bit oe_seen = 0;
    logic [7:0] mem_m [DEPTH];
    logic [7:0] wbuf [64];

    always #10 clk = ~clk;

    spi_eeprom_page_wr #(.ADDR_BITS(AB), .PAGE_BYTES(32), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        if (!mode3) begin
            mosi = b; wt(H);
            r = miso; if (miso_oe) oe_seen = 1;
            sck = 1'b1; wt(H); sck = 1'b0;
        end else begin
            sck = 1'b0; mosi = b; wt(H);
            r = miso; if (miso_oe) oe_seen = 1;
            sck = 1'b1; wt(H);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
    endtask

    task automatic fopen();
        sck = mode3; wt(2); cs_n = 1'b0; wt(H);
    endtask

    task automatic fclose();
        wt(H); cs_n = 1'b1; wt(2 * H);
    endtask

    task automatic read_status(output logic [7:0] s);
        logic [7:0] d;
        fopen(); xbyte(8'h05, d); xbyte(8'h00, s); fclose();
    endtask

    task automatic arm();
        logic [7:0] d;
        fopen(); xbyte(8'h06, d); fclose();
    endtask

    task automatic send_write(input logic [15:0] a, input int n, input bit close_it);
        logic [7:0] d;
        fopen(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
        for (int i = 0; i < n; i++) xbyte(wbuf[i], d);
        if (close_it) fclose();
    endtask

    task automatic model_prog(input logic [15:0] a, input int n);
        logic [4:0] off;
        off = a[4:0];
        for (int i = 0; i < n; i++) begin
            mem_m[{a[AB-1:5], off}] = wbuf[i];
            off = off + 5'd1;
        end
    endtask

    task automatic mem_cmp(input string req);
        int bad;
        bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AB'(a); #2;
            if (rd_data !== mem_m[a]) bad++;
        end
        chk(req, bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, s2, d;
        logic [15:0] a;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
        wt(5); rst = 1'b0; wt(5);

        // R1 reset state
        chk("R1 miso_oe after reset", miso_oe, 0);
        oe_seen = 0;
        fopen(); xbyte(8'h05, d); xbyte(8'h00, s); xbyte(8'h00, s2); fclose();
        chk("R1 status after reset", s, 8'h00);
        chk("R12 status byte repeats", s2, s);
        chk("R12 miso_oe during status data", oe_seen, 1);
        chk("R12 miso_oe after deselect", miso_oe, 0);
        mem_cmp("R1 array cleared");

        // R3 write without enable
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
        send_write(16'h0040, 4, 1);
        read_status(s);
        chk("R3 no cycle without enable", s, 8'h00);
        wt(PROG + 60);
        mem_cmp("R3 array untouched");

        // R2 enable
        arm(); read_status(s);
        chk("R2 enable flag set", s, 8'h02);

        // R7 hold chip select low long after data
        for (int i = 0; i < 3; i++) wbuf[i] = 8'h11 * 8'(i + 1);
        oe_seen = 0;
        send_write(16'h0123, 3, 0);
        wt(PROG + 200);
        chk("R12 miso quiet during write", oe_seen, 0);
        mem_cmp("R7 no commit while selected");
        fclose();
        model_prog(16'h0123, 3);
        read_status(s);
        chk("R8 busy after deselect", s, 8'h03);
        // R9 commands while busy
        wbuf[0] = 8'h5A;
        send_write(16'h0200, 1, 1);
        read_status(s);
        chk("R9 status readable while busy", s, 8'h03);
        wt(PROG + 60);
        read_status(s);
        chk("R10 flag cleared, not busy", s, 8'h00);
        mem_cmp("R5 R9 consecutive bytes, busy write dropped");

        // R6 R4 wrap in mode 3 with upper address garbage
        mode3 = 1;
        arm();
        for (int i = 0; i < 36; i++) wbuf[i] = 8'(8'h40 + i);
        send_write(16'hA3FC, 36, 1);
        model_prog(16'hA3FC, 36);
        wt(PROG + 60);
        mem_cmp("R6 R4 page wrap with ignored upper bits");
        mode3 = 0;

        // R11 aborted frames
        arm();
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        send_write(16'h0300, 2, 0);
        for (int i = 0; i < 3; i++) xbit(1'b1, d[0]);
        fclose();
        read_status(s);
        chk("R11 partial byte aborts, flag kept", s, 8'h02);
        send_write(16'h0300, 0, 1);
        read_status(s);
        chk("R11 no data byte aborts", s, 8'h02);
        wbuf[0] = 8'hC3;
        send_write(16'h0010, 1, 1);
        model_prog(16'h0010, 1);
        wt(PROG + 60);
        mem_cmp("R11 discarded bytes not committed");

        // R13 R5 R6 random frames in both modes
        for (int it = 0; it < 12; it++) begin
            mode3 = 1'($urandom % 2);
            a = 16'($urandom);
            n = 1 + int'($urandom % 40);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            arm();
            read_status(s);
            chk("R2 enable in random frame", s, 8'h02);
            send_write(a, n, 1);
            model_prog(a, n);
            wt(PROG + 60);
            read_status(s);
            chk("R10 idle after random write", s, 8'h00);
            mem_cmp("R13 random write in mode 0/3");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule